// File: doc/BRIEF.md
# Two-Layer Perceptron Online Training Engine

This block trains a small two-layer perceptron on one sample per run. There are M inputs, N hidden neurons and K outputs. The input sample and both weight layers are held on-chip. Software-side logic fills them through a simple write port while the block is idle and inspects them through a combinational read port.

A start pulse latches a K-entry target vector and launches a fixed schedule:
- a neuron-parallel forward pass over the inputs;
- a neuron-serial pass through the output layer;
- output activation together with the output deltas;
- an in-place rewrite of the output weights;
- a column fetch and the hidden error;
- learning-rate scaling of the hidden deltas;
- a pixel-serial rewrite of the hidden weights.

All values are signed Q4.12 with saturation at every accumulation. Activations and their derivative terms come from a 16-entry table, and the learning rate is a right shift.

One training step always takes 2M+3N+3K cycles. Of these, M+N+K are forward and 2K+2N+M are backward. This makes the throughput of an outer epoch loop exact and predictable.

Top module: `mlp_trainer`

## Requirements
- R1: After reset the block is idle (busy and done low), and every input, hidden-weight and output-weight location reads zero.
- R2: While idle, a write with ld_we stores ld_data at the location chosen by ld_sel. The encodings are: 0 = input, with row as the input index; 1 = hidden weight, with row as the input index and col as the hidden neuron; 2 = output weight, with row as the output index and col as the hidden neuron. The read port uses the same encoding, rd_sel = 3 reads zero, and a training step never changes the input memory.
- R3: busy rises the cycle after start is sampled and stays high for exactly 2M+3N+3K cycles. done is a single-cycle pulse in the first idle cycle.
- R4: All products are (a*b) shifted right arithmetically by 12 and then saturated to [-32768, 32767]. Each hidden sum starts from zero and adds, in input order, the product of input i and hidden weight (i,j), with saturation after every add. Each output sum does the same over hidden index j with activation H_j and output weight (k,j).
- R5: The activation of a sum s works as follows. Clamp s to [-16384, 16383] and form idx = (s+16384)>>11. Then activation = idx*256+128, and the derivative term is (act*(4096-act))>>12.
- R6: For each output k, err_k = sat(target_k - O_k), and delta2_k = mul(err_k, Obar_k).
- R7: Each output weight (k,j) becomes sat(w + (mul(delta2_k, H_j) >>> 4)).
- R8: The hidden error for neuron j is sat(sum over k of mul(delta2_k, updated output weight (k,j))). Then delta1_j = mul(error_j, Hbar_j) >>> 4, and each hidden weight (i,j) becomes sat(w + mul(x_i, delta1_j)).
- R9: The target is captured at start. A start or a target change while busy has no effect on the run, its length or its results.
- R10: Writes through the load port while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one training step (accepted when idle) |
| target | input | K*W | Target vector, entry k at bits k*W +: W |
| busy | output | 1 | Training step in progress |
| done | output | 1 | One-cycle pulse after a step completes |
| ld_we | input | 1 | Load-port write strobe |
| ld_sel | input | 2 | Load-port memory select |
| ld_row | input | max(clog2 M, clog2 K) | Load-port row index |
| ld_col | input | clog2 N | Load-port column index |
| ld_data | input | W | Load-port write data |
| rd_sel | input | 2 | Read-port memory select |
| rd_row | input | max(clog2 M, clog2 K) | Read-port row index |
| rd_col | input | clog2 N | Read-port column index |
| rd_data | output | W | Read-port data (combinational) |

## Verification
A wrong phase counter or a wrong next-state entry shows first at busy, whose length differs from 2M+3N+3K on the very step where it happens. A fault in the forward sums, the table, the output deltas or the hidden error stays hidden until done. It then appears in the weights read back right after that step. Because every hidden weight depends on every upstream term, a single wrong value usually spoils many readback entries. Chained steps carry any corruption forward, so a second run on the updated weights exposes faults that a one-step result might mask.

// File: rtl/mlp_trainer.sv
`timescale 1ns/1ps
module mlp_trainer #(
  parameter int M = 8,
  parameter int N = 4,
  parameter int K = 3,
  parameter int W = 16,
  parameter int FRAC = 12,
  parameter int LR = 4,
  localparam int MI = $clog2(M),
  localparam int NI = $clog2(N),
  localparam int KI = $clog2(K),
  localparam int RW = (MI > KI) ? MI : KI,
  localparam int TOTAL = 2*M + 3*N + 3*K
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [K*W-1:0] target,
  output logic           busy,
  output logic           done,
  input  logic           ld_we,
  input  logic [1:0]     ld_sel,
  input  logic [RW-1:0]  ld_row,
  input  logic [NI-1:0]  ld_col,
  input  logic [W-1:0]   ld_data,
  input  logic [1:0]     rd_sel,
  input  logic [RW-1:0]  rd_row,
  input  logic [NI-1:0]  rd_col,
  output logic [W-1:0]   rd_data
);
  localparam int CW = $clog2(M + N + K);
  localparam int ONE = 1 << FRAC;
  localparam int LIM = 4 * ONE;
  localparam int MAXV = (1 << (W-1)) - 1;
  localparam int MINV = -(1 << (W-1));

  typedef enum logic [3:0] {IDLE, FWD_HID, FWD_OUT, OUT_ACT, UPD_OUT, FETCH, ERR_HID, SCALE, UPD_HID} st_t;
  typedef logic signed [W-1:0] val_t;

  function automatic val_t sat(input logic signed [31:0] v);
    if (v > MAXV) return val_t'(MAXV);
    if (v < MINV) return val_t'(MINV);
    return val_t'(v);
  endfunction

  function automatic val_t mul(input val_t a, input val_t b);
    logic signed [31:0] p;
    p = 32'(a) * 32'(b);
    return sat(p >>> FRAC);
  endfunction

  function automatic logic [3:0] lidx(input val_t s);
    logic signed [31:0] c;
    c = 32'(s);
    if (c < -LIM) c = -LIM;
    if (c > LIM - 1) c = LIM - 1;
    c = (c + LIM) >>> (FRAC - 1);
    return c[3:0];
  endfunction

  st_t st, nxt;
  logic [CW-1:0] cnt;
  int plen;
  logic last;

  val_t xm [M];
  val_t w1 [M][N];
  val_t w2 [K][N];
  val_t wc [K][N];
  val_t tgt [K];
  val_t hacc [N];
  val_t oacc [K];
  val_t d2 [K];
  val_t d1 [N];
  val_t h [N];
  val_t hb [N];
  val_t lut_h [16];
  val_t lut_hb [16];

  for (genvar g = 0; g < 16; g++) begin : g_lut
    localparam int HV = g * (ONE / 16) + ONE / 32;
    assign lut_h[g]  = val_t'(HV);
    assign lut_hb[g] = val_t'((HV * (ONE - HV)) >>> FRAC);
  end

  for (genvar j = 0; j < N; j++) begin : g_hid
    assign h[j]  = lut_h[lidx(hacc[j])];
    assign hb[j] = lut_hb[lidx(hacc[j])];
  end

  wire [MI-1:0] cm = cnt[MI-1:0];
  wire [NI-1:0] cn = cnt[NI-1:0];
  wire [KI-1:0] ck = cnt[KI-1:0];

  val_t o_act, o_bar, o_err, e1;
  assign o_act = lut_h[lidx(oacc[ck])];
  assign o_bar = lut_hb[lidx(oacc[ck])];
  assign o_err = sat(32'(tgt[ck]) - 32'(o_act));

  always_comb begin
    logic signed [31:0] acc;
    acc = '0;
    for (int k = 0; k < K; k++) acc = acc + 32'(mul(d2[k], wc[k][cn]));
    e1 = sat(acc);
  end

  always_comb begin
    case (st)
      FWD_HID: begin plen = M; nxt = FWD_OUT; end
      FWD_OUT: begin plen = N; nxt = OUT_ACT; end
      OUT_ACT: begin plen = K; nxt = UPD_OUT; end
      UPD_OUT: begin plen = K; nxt = FETCH;   end
      FETCH:   begin plen = K; nxt = ERR_HID; end
      ERR_HID: begin plen = N; nxt = SCALE;   end
      SCALE:   begin plen = N; nxt = UPD_HID; end
      UPD_HID: begin plen = M; nxt = IDLE;    end
      default: begin plen = 1; nxt = IDLE;    end
    endcase
  end
  assign last = (int'(cnt) == plen - 1);
  assign busy = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      cnt <= '0;
      done <= 1'b0;
      for (int i = 0; i < M; i++) begin
        xm[i] <= '0;
        for (int j = 0; j < N; j++) w1[i][j] <= '0;
      end
      for (int k = 0; k < K; k++) begin
        tgt[k] <= '0; oacc[k] <= '0; d2[k] <= '0;
        for (int j = 0; j < N; j++) begin w2[k][j] <= '0; wc[k][j] <= '0; end
      end
      for (int j = 0; j < N; j++) begin hacc[j] <= '0; d1[j] <= '0; end
    end else begin
      done <= 1'b0;
      case (st)
        IDLE:
          if (start) begin
            st <= FWD_HID;
            cnt <= '0;
            for (int k = 0; k < K; k++) begin tgt[k] <= target[k*W +: W]; oacc[k] <= '0; end
            for (int j = 0; j < N; j++) hacc[j] <= '0;
          end else if (ld_we) begin
            case (ld_sel)
              2'd0: if (int'(ld_row) < M) xm[ld_row[MI-1:0]] <= ld_data;
              2'd1: if (int'(ld_row) < M) w1[ld_row[MI-1:0]][ld_col] <= ld_data;
              2'd2: if (int'(ld_row) < K) w2[ld_row[KI-1:0]][ld_col] <= ld_data;
              default: ;
            endcase
          end
        FWD_HID: for (int j = 0; j < N; j++) hacc[j] <= sat(32'(hacc[j]) + 32'(mul(xm[cm], w1[cm][j])));
        FWD_OUT: for (int k = 0; k < K; k++) oacc[k] <= sat(32'(oacc[k]) + 32'(mul(h[cn], w2[k][cn])));
        OUT_ACT: d2[ck] <= mul(o_err, o_bar);
        UPD_OUT: for (int j = 0; j < N; j++) w2[ck][j] <= sat(32'(w2[ck][j]) + 32'(mul(d2[ck], h[j]) >>> LR));
        FETCH:   for (int j = 0; j < N; j++) wc[ck][j] <= w2[ck][j];
        ERR_HID: d1[cn] <= mul(e1, hb[cn]);
        SCALE:   d1[cn] <= d1[cn] >>> LR;
        UPD_HID: for (int j = 0; j < N; j++) w1[cm][j] <= sat(32'(w1[cm][j]) + 32'(mul(xm[cm], d1[j])));
        default: ;
      endcase
      if (st != IDLE) begin
        if (last) begin
          cnt <= '0;
          st <= nxt;
          done <= (st == UPD_HID);
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      2'd0: if (int'(rd_row) < M) rd_data = xm[rd_row[MI-1:0]];
      2'd1: if (int'(rd_row) < M) rd_data = w1[rd_row[MI-1:0]][rd_col];
      2'd2: if (int'(rd_row) < K) rd_data = w2[rd_row[KI-1:0]][rd_col];
      default: ;
    endcase
  end
endmodule

module mlp_trainer_chk #(
  parameter int TOTAL = 37
)(
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done
);
  logic [15:0] bc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bc <= '0;
    else if (busy) bc <= bc + 16'd1;
    else bc <= '0;
  end

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bc == 16'(TOTAL)));
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_start_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
  assert_no_early_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bc < 16'(TOTAL - 1)) |=> busy);
endmodule

bind mlp_trainer mlp_trainer_chk #(.TOTAL(TOTAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
);

// File: tb/test_mlp_trainer.sv
`timescale 1ns/1ps
module test_mlp_trainer;
  localparam int M = 8, N = 4, K = 3, W = 16, LR = 4;
  localparam int T = 2*M + 3*N + 3*K;

  logic clk = 0, rst_n = 0, start = 0, ld_we = 0, busy, done;
  logic [K*W-1:0] target = '0;
  logic [1:0] ld_sel = 0, rd_sel = 0;
  logic [2:0] ld_row = 0, rd_row = 0;
  logic [1:0] ld_col = 0, rd_col = 0;
  logic [W-1:0] ld_data = 0, rd_data;

  mlp_trainer i_mlp_trainer (.clk(clk), .rst_n(rst_n), .start(start), .target(target),
    .busy(busy), .done(done), .ld_we(ld_we), .ld_sel(ld_sel), .ld_row(ld_row),
    .ld_col(ld_col), .ld_data(ld_data), .rd_sel(rd_sel), .rd_row(rd_row),
    .rd_col(rd_col), .rd_data(rd_data));

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int bx [M];
  int bw1 [M][N];
  int bw2 [K][N];

  typedef struct { int sel; int row; int col; int val; string req; } item_t;
  item_t q [$];

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bsat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction
  function automatic int bmul(int a, int b);
    longint p = longint'(a) * longint'(b);
    return bsat(p >>> 12);
  endfunction
  function automatic int act_h(int s);
    int c = s;
    if (c < -16384) c = -16384;
    if (c > 16383) c = 16383;
    return ((c + 16384) >>> 11) * 256 + 128;
  endfunction
  function automatic int act_d(int s);
    int a = act_h(s);
    return (a * (4096 - a)) >>> 12;
  endfunction

  task automatic readv(int sel, int row, int col, output int v);
    rd_sel = 2'(sel); rd_row = 3'(row); rd_col = 2'(col);
    #1 v = int'($signed(rd_data));
  endtask

  task automatic load(int sel, int row, int col, int val);
    @(negedge clk);
    ld_we = 1; ld_sel = 2'(sel); ld_row = 3'(row); ld_col = 2'(col); ld_data = 16'(val);
    @(negedge clk);
    ld_we = 0;
    if (!busy) begin
      if (sel == 0) bx[row] = val;
      else if (sel == 1) bw1[row][col] = val;
      else if (sel == 2) bw2[row][col] = val;
    end
  endtask

  // driver: model a step, push expected readback items, run the block
  task automatic run_step(int t0, int t1, int t2, bit disturb);
    int tv [K];
    int hs [N], hh [N], hd [N], d2 [K], d1 [N];
    int s, o, ob, e;
    item_t it;
    tv[0] = t0; tv[1] = t1; tv[2] = t2;
    for (int j = 0; j < N; j++) begin
      s = 0;
      for (int i = 0; i < M; i++) s = bsat(longint'(s) + bmul(bx[i], bw1[i][j]));
      hs[j] = s; hh[j] = act_h(s); hd[j] = act_d(s);
    end
    for (int k = 0; k < K; k++) begin
      s = 0;
      for (int j = 0; j < N; j++) s = bsat(longint'(s) + bmul(hh[j], bw2[k][j]));
      o = act_h(s); ob = act_d(s);
      e = bsat(longint'(tv[k]) - o);
      d2[k] = bmul(e, ob);
    end
    for (int k = 0; k < K; k++)
      for (int j = 0; j < N; j++)
        bw2[k][j] = bsat(longint'(bw2[k][j]) + (bmul(d2[k], hh[j]) >>> LR));
    for (int j = 0; j < N; j++) begin
      longint acc = 0;
      for (int k = 0; k < K; k++) acc += bmul(d2[k], bw2[k][j]);
      d1[j] = bmul(bsat(acc), hd[j]) >>> LR;
    end
    for (int i = 0; i < M; i++)
      for (int j = 0; j < N; j++)
        bw1[i][j] = bsat(longint'(bw1[i][j]) + bmul(bx[i], d1[j]));
    for (int k = 0; k < K; k++)
      for (int j = 0; j < N; j++) begin
        it.sel = 2; it.row = k; it.col = j; it.val = bw2[k][j]; it.req = "R7 output weight"; q.push_back(it);
      end
    for (int i = 0; i < M; i++)
      for (int j = 0; j < N; j++) begin
        it.sel = 1; it.row = i; it.col = j; it.val = bw1[i][j]; it.req = "R8 hidden weight"; q.push_back(it);
      end
    for (int i = 0; i < M; i++) begin
      it.sel = 0; it.row = i; it.col = 0; it.val = bx[i]; it.req = "R2 input kept"; q.push_back(it);
    end
    @(negedge clk);
    target = {16'(t2), 16'(t1), 16'(t0)};
    start = 1;
    @(negedge clk);
    start = 0;
    if (disturb) begin
      repeat (3) @(negedge clk);
      target = {16'(-4096), 16'(-4096), 16'(-4096)};
      start = 1;                     // R9: ignored while busy
      @(negedge clk);
      start = 0;
      load(2, 0, 0, 32767);          // R10: ignored while busy
      load(1, 1, 1, -32768);         // R10: ignored while busy
    end
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  // monitor: busy length, done width, and expected readback after each done
  int bcount = 0;
  bit done_prev = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_prev) check("R3 done single pulse", int'(done), 0);
      done_prev = done;
      if (busy) bcount++;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        int v;
        item_t it;
        check("R3 busy length", bcount, T);
        bcount = 0;
        while (q.size() > 0) begin
          it = q.pop_front();
          readv(it.sel, it.row, it.col, v);
          check(it.req, v, it.val);
        end
      end
    end
  end

  function automatic int pat(int seed, int a, int b);
    return ((seed * 131 + a * 71 + b * 29 + a * b * 17) % 4096) - 2048;
  endfunction

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 busy after reset", int'(busy), 0);
    check("R1 done after reset", int'(done), 0);
    readv(0, 3, 0, v); check("R1 input zero", v, 0);
    readv(1, 5, 2, v); check("R1 hidden weight zero", v, 0);
    readv(2, 1, 3, v); check("R1 output weight zero", v, 0);
    for (int i = 0; i < M; i++) begin bx[i] = 0; for (int j = 0; j < N; j++) bw1[i][j] = 0; end
    for (int k = 0; k < K; k++) for (int j = 0; j < N; j++) bw2[k][j] = 0;

    // pattern A: moderate values
    for (int i = 0; i < M; i++) load(0, i, 0, pat(3, i, 0) * 2);
    for (int i = 0; i < M; i++) for (int j = 0; j < N; j++) load(1, i, j, pat(7, i, j));
    for (int k = 0; k < K; k++) for (int j = 0; j < N; j++) load(2, k, j, pat(11, k, j) * 3);
    readv(0, 5, 0, v); check("R2 input readback", v, bx[5]);
    readv(1, 3, 2, v); check("R2 hidden weight readback", v, bw1[3][2]);
    readv(2, 2, 3, v); check("R2 output weight readback", v, bw2[2][3]);
    readv(3, 1, 1, v); check("R2 select 3 reads zero", v, 0);
    run_step(4096, 0, 2048, 0);     // R4 R5 R6 R7 R8
    run_step(0, 4096, -2048, 0);    // chained step on updated weights

    // pattern B: positive saturation, top table entry (R4, R5)
    for (int i = 0; i < M; i++) load(0, i, 0, 28672);
    for (int i = 0; i < M; i++) for (int j = 0; j < N; j++) load(1, i, j, 28672);
    for (int k = 0; k < K; k++) for (int j = 0; j < N; j++) load(2, k, j, 20000);
    run_step(-8192, 8192, 0, 0);

    // pattern C: negative saturation, bottom table entry (R4, R5)
    for (int i = 0; i < M; i++) for (int j = 0; j < N; j++) load(1, i, j, -28672);
    for (int k = 0; k < K; k++) for (int j = 0; j < N; j++) load(2, k, j, -3000 + k * 1000 + j * 500);
    run_step(4096, 4096, 4096, 0);

    // pattern D: disturbances while busy (R9, R10)
    for (int i = 0; i < M; i++) load(0, i, 0, pat(5, i, 1) * 3);
    for (int i = 0; i < M; i++) for (int j = 0; j < N; j++) load(1, i, j, pat(13, i, j) * 2);
    run_step(2048, -1024, 3072, 1);
    readv(2, 0, 0, v); check("R10 write while busy ignored", v, bw2[0][0]);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule